// File: doc/BRIEF.md
# CD subcode serial output

This block places CD subcode bytes onto a one-bit serial line that runs beside an I2S audio stream. A companion sync line marks the start of each byte, so that a receiver can find the byte boundaries. It times itself from the audio word clock, which it samples in the system clock domain. Every six word-clock periods it starts a new frame. Each frame carries one subcode byte, most significant bit first, at one bit per half word-clock period. The remaining slots of the frame stay low.

The sync pulse takes one of two widths. For an ordinary byte it lasts half a word-clock period. When the byte is a subcode-block sync symbol it lasts a full period. When 4x upsampling is on, the audio word clock runs four times faster, but the subcode keeps its old pace. The block then counts four word-clock edges per bit slot, which matches a receiver that samples with the word clock divided by four.

Bytes are written through a valid strobe into a one-entry holding register. That register is read only when a new frame begins, so the byte being sent is never disturbed. If no byte is waiting when a frame begins, an ordinary frame of zeros is sent.

Top module: `cd_subcode_tx`

## Requirements
- R1: After reset, and until the first word-clock edge is seen, `sub_o` and `sync_o` are both 0.
- R2: A frame is 12 slots. Slot 0 begins at a word-clock edge. Slots 0 to 7 carry bits 7 down to 0 of the frame's byte, MSB in slot 0.
- R3: Slots 8 to 11 of every frame drive `sub_o` = 0.
- R4: Successive rising edges of `sync_o` are exactly 12 slots apart, which is six word-clock periods in normal mode.
- R5: For an ordinary byte (`sc_blk_i` = 0 when it was written), `sync_o` is 1 in slot 0 only, which is half a word-clock period.
- R6: For a block-sync byte (`sc_blk_i` = 1 when it was written), `sync_o` is 1 in slots 0 and 1, which is a full word-clock period.
- R7: If no byte has been written since the previous frame began, the frame carries 0x00 with an ordinary sync pulse.
- R8: A byte written during a frame is sent in the next frame, and the current frame is unchanged. If several bytes are written in one frame, the last one written is sent.
- R9: With `ups_en_i` = 1, each slot lasts four word-clock half-periods (two periods), and the slot order and sync widths are unchanged.
- R10: `sub_o` and `sync_o` change only at slot boundaries. They hold steady for the whole of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Audio word clock, sampled on `clk` |
| ups_en_i | input | 1 | 1 = upsampled audio, four word-clock edges per slot |
| sc_valid_i | input | 1 | Writes `sc_byte_i` and `sc_blk_i` into the holding register |
| sc_byte_i | input | 8 | Subcode byte |
| sc_blk_i | input | 1 | 1 = byte is a subcode-block sync symbol |
| sub_o | output | 1 | Serial subcode line |
| sync_o | output | 1 | Byte-start strobe |

## Verification
The hardest situation to reach from the ports is the hand-off between a byte that is still shifting out and a new byte that has just been written. This covers both an overwrite inside one frame and a frame that gets no byte at all. The stimulus writes bytes at fixed slots in the middle of a frame, writes twice within one frame, and skips writes in others. It then compares every slot of the following frames against a queue of expected bit and sync values. The switch into upsampling and back is made at a frame boundary. Each slot is sampled both just after its first word-clock edge and at its end, which exposes any output that moves in the middle of a slot.

// File: rtl/cd_subcode_pkg.sv
`timescale 1ns/1ps
package cd_subcode_pkg;

    // Width of one subcode byte
    localparam int unsigned SC_BITS = 8;

    // A byte as held and shifted: payload plus block-sync marker
    typedef struct packed {
        logic                 blk;
        logic [SC_BITS-1:0]   data;
    } sc_word_t;

    // Word sent when nothing is waiting at a frame start
    localparam sc_word_t SC_FILL = '{blk: 1'b0, data: '0};

    // Bit that goes out in slot idx: MSB first, zero after the byte
    function automatic logic pick_msb_first(input logic [SC_BITS-1:0] d,
                                            input int unsigned idx);
        logic b;
        b = 1'b0;
        for (int unsigned i = 0; i < SC_BITS; i++) begin
            if (idx == i) begin
                b = d[SC_BITS-1-i];
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/cd_subcode_tick.sv
`timescale 1ns/1ps
// Turns word-clock edges into slot ticks; divides by UPS_RATIO in upsampling mode
module cd_subcode_tick #(
    parameter int unsigned UPS_RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_i,
    input  logic ups_en_i,
    output logic tick_o
);

    logic wclk_q;
    logic edge_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= wclk_i;
        end
    end

    assign edge_w = wclk_i ^ wclk_q;

    generate
        if (UPS_RATIO > 1) begin : g_div
            localparam int unsigned CW = $clog2(UPS_RATIO);
            localparam logic [CW-1:0] CLAST = CW'(UPS_RATIO - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (!ups_en_i) begin
                    cnt_q <= '0;
                end else if (edge_w) begin
                    cnt_q <= (cnt_q == CLAST) ? '0 : cnt_q + CW'(1);
                end
            end

            assign tick_o = edge_w && (!ups_en_i || (cnt_q == '0));
        end else begin : g_nodiv
            logic unused_ups;
            assign unused_ups = ups_en_i;
            assign tick_o     = edge_w;
        end
    endgenerate

endmodule

// File: rtl/cd_subcode_hold.sv
`timescale 1ns/1ps
// One-entry holding register between the writer and the frame sequencer
module cd_subcode_hold
    import cd_subcode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  sc_word_t wr_word_i,
    input  logic     take_i,
    output sc_word_t next_o
);

    sc_word_t held_q;
    logic     full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= SC_FILL;
            full_q <= 1'b0;
        end else begin
            if (take_i) begin
                full_q <= 1'b0;
            end
            if (wr_i) begin
                held_q <= wr_word_i;
                full_q <= 1'b1;
            end
        end
    end

    assign next_o = full_q ? held_q : SC_FILL;

endmodule

// File: rtl/cd_subcode_seq.sv
`timescale 1ns/1ps
// Slot counter, byte register and output decode for one frame
module cd_subcode_seq
    import cd_subcode_pkg::*;
#(
    parameter  int unsigned FRAME_WCLK = 6,
    localparam int unsigned SLOTS      = 2 * FRAME_WCLK,
    localparam int unsigned SW         = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  sc_word_t      next_i,
    output logic          take_o,
    output logic          active_o,
    output logic [SW-1:0] slot_o,
    output logic          sub_o,
    output logic          sync_o
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic          active_q;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_nx;
    sc_word_t      cur_q;

    always_comb begin
        if (!active_q || (slot_q == LAST)) begin
            slot_nx = '0;
        end else begin
            slot_nx = slot_q + SW'(1);
        end
    end

    assign take_o = tick_i && (slot_nx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            cur_q    <= SC_FILL;
        end else if (tick_i) begin
            active_q <= 1'b1;
            slot_q   <= slot_nx;
            if (slot_nx == '0) begin
                cur_q <= next_i;
            end
        end
    end

    assign sub_o    = active_q && pick_msb_first(cur_q.data, 32'(slot_q));
    assign sync_o   = active_q && ((slot_q == '0) || ((slot_q == SW'(1)) && cur_q.blk));
    assign active_o = active_q;
    assign slot_o   = slot_q;

endmodule

// File: rtl/cd_subcode_tx.sv
`timescale 1ns/1ps
module cd_subcode_tx
    import cd_subcode_pkg::*;
#(
    parameter int unsigned FRAME_WCLK = 6,
    parameter int unsigned UPS_RATIO  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wclk_i,
    input  logic               ups_en_i,
    input  logic               sc_valid_i,
    input  logic [SC_BITS-1:0] sc_byte_i,
    input  logic               sc_blk_i,
    output logic               sub_o,
    output logic               sync_o
);

    localparam int unsigned SLOTS = 2 * FRAME_WCLK;
    localparam int unsigned SW    = $clog2(SLOTS);

    logic          tick;
    logic          take;
    logic          active;
    logic [SW-1:0] slot;
    sc_word_t      wr_word;
    sc_word_t      next_word;

    assign wr_word = '{blk: sc_blk_i, data: sc_byte_i};

    cd_subcode_tick #(.UPS_RATIO(UPS_RATIO)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .wclk_i   (wclk_i),
        .ups_en_i (ups_en_i),
        .tick_o   (tick)
    );

    cd_subcode_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (sc_valid_i),
        .wr_word_i (wr_word),
        .take_i    (take),
        .next_o    (next_word)
    );

    cd_subcode_seq #(.FRAME_WCLK(FRAME_WCLK)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .next_i   (next_word),
        .take_o   (take),
        .active_o (active),
        .slot_o   (slot),
        .sub_o    (sub_o),
        .sync_o   (sync_o)
    );

endmodule

// File: rtl/cd_subcode_tx_chk.sv
`timescale 1ns/1ps
module cd_subcode_tx_chk
    import cd_subcode_pkg::*;
#(
    parameter  int unsigned FRAME_WCLK = 6,
    localparam int unsigned SLOTS      = 2 * FRAME_WCLK,
    localparam int unsigned SW         = $clog2(SLOTS),
    localparam int unsigned GW         = $clog2(SLOTS + 2) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          active,
    input logic [SW-1:0] slot,
    input logic          sub,
    input logic          sync
);

    logic          sync_q;
    logic          rise_w;
    logic [1:0]    run_q;
    logic [GW-1:0] gap_q;
    logic          seen_q;

    assign rise_w = sync && !sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            run_q  <= 2'd0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= sync;
            if (tick) begin
                run_q <= sync ? ((run_q == 2'd3) ? run_q : run_q + 2'd1) : 2'd0;
            end
            if (rise_w) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (tick && (gap_q != '1)) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!sub && !sync));

    p_tail_low_r3: assert property (@(posedge clk) disable iff (rst)
        (active && (32'(slot) >= SC_BITS)) |-> !sub);

    p_frame_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (rise_w && seen_q) |-> (gap_q == GW'(SLOTS)));

    p_sync_first_slot_r5: assert property (@(posedge clk) disable iff (rst)
        rise_w |-> (active && (slot == '0)));

    p_sync_width_r6: assert property (@(posedge clk) disable iff (rst)
        run_q != 2'd3);

    p_hold_in_slot_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(sub) && $stable(sync)));

endmodule

bind cd_subcode_tx cd_subcode_tx_chk #(.FRAME_WCLK(FRAME_WCLK)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .active (active),
    .slot   (slot),
    .sub    (sub_o),
    .sync   (sync_o)
);

// File: tb/cd_subcode_tx_tb.sv
`timescale 1ns/1ps
module cd_subcode_tx_tb;

    localparam int HP    = 8;   // clk cycles per word-clock half-period
    localparam int SLOTS = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wclk = 1'b0;
    logic       ups = 1'b0;
    logic       vld = 1'b0;
    logic       blk = 1'b0;
    logic [7:0] byt = 8'h00;
    logic       sub;
    logic       sync;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit sub;
        bit sync;
        int tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    event probe_ev;
    bit   probe_late = 0;
    int   slot_ix = 0;
    int   last_rise = -1;
    bit   prev_sync = 0;

    always #2.5 clk = ~clk;

    cd_subcode_tx u_dut (
        .clk        (clk),
        .rst        (rst),
        .wclk_i     (wclk),
        .ups_en_i   (ups),
        .sc_valid_i (vld),
        .sc_byte_i  (byt),
        .sc_blk_i   (blk),
        .sub_o      (sub),
        .sync_o     (sync)
    );

    function automatic string rname(int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s slot %0d: got %0d expected %0d", req, slot_ix, act, exp_v);
        end
    endtask

    // Scoreboard driver: expected sub/sync for every slot of one frame
    task automatic push_frame(input logic [7:0] d, input bit b, input int ctx);
        exp_t x;
        for (int s = 0; s < SLOTS; s++) begin
            x.sub  = (s < 8) ? d[7-s] : 1'b0;
            x.sync = (s == 0) || ((s == 1) && b);
            if (s == 0)             x.tag = b ? 6 : 5;
            else if (s == 1 && b)   x.tag = 6;
            else if (s < 8)         x.tag = ctx;
            else                    x.tag = 3;
            q.push_back(x);
        end
    endtask

    // Monitor: compares outputs with the head of the queue
    always begin
        @(probe_ev);
        if (q.size() == 0) begin
            chk(1'b0, "R2", int'({sub, sync}), -1);
        end else begin
            e = q[0];
            chk((sub == e.sub) && (sync == e.sync),
                probe_late ? rname(e.tag) : "R10",
                int'({sub, sync}), int'({e.sub, e.sync}));
            if (probe_late) begin
                if (sync && !prev_sync) begin
                    if (last_rise >= 0) begin
                        chk((slot_ix - last_rise) == SLOTS, "R4", slot_ix - last_rise, SLOTS);
                    end
                    last_rise = slot_ix;
                end
                prev_sync = sync;
                slot_ix++;
                void'(q.pop_front());
            end
        end
    end

    task automatic probe(input bit late);
        probe_late = late;
        -> probe_ev;
        #0;
    endtask

    task automatic run_slot(input bit up);
        int n;
        n = up ? 4 : 1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wclk = ~wclk;
            repeat (2) @(negedge clk);
            if (k == 0) probe(1'b0);
            repeat (HP - 3) @(negedge clk);
        end
        probe(1'b1);
    endtask

    task automatic write_byte(input logic [7:0] d, input bit b);
        vld = 1'b1;
        byt = d;
        blk = b;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic run_frame(input bit up, input logic [7:0] ed, input bit eb, input int ctx,
                             input bit w1, input logic [7:0] d1, input bit b1,
                             input bit w2, input logic [7:0] d2, input bit b2);
        push_frame(ed, eb, ctx);
        for (int s = 0; s < SLOTS; s++) begin
            run_slot(up);
            if (s == 3 && w1) write_byte(d1, b1);
            if (s == 6 && w2) write_byte(d2, b2);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!sub && !sync, "R1", int'({sub, sync}), 0);

        // R7: nothing written before the first frame
        run_frame(0, 8'h00, 0, 7, 1, 8'hA5, 0, 0, 8'h00, 0);
        // R2 / R5: ordinary byte
        run_frame(0, 8'hA5, 0, 2, 1, 8'h3C, 1, 0, 8'h00, 0);
        // R6: block-sync byte; two writes in this frame for R8
        run_frame(0, 8'h3C, 1, 2, 1, 8'h81, 0, 1, 8'h5E, 0);
        // R8: last write wins
        run_frame(0, 8'h5E, 0, 8, 0, 8'h00, 0, 0, 8'h00, 0);
        // R7: no write during previous frame
        run_frame(0, 8'h00, 0, 7, 1, 8'hFF, 1, 0, 8'h00, 0);
        run_frame(0, 8'hFF, 1, 2, 1, 8'h96, 0, 0, 8'h00, 0);
        // R9: upsampling, four word-clock edges per slot
        ups = 1'b1;
        run_frame(1, 8'h96, 0, 9, 1, 8'h6B, 1, 0, 8'h00, 0);
        run_frame(1, 8'h6B, 1, 9, 1, 8'h01, 0, 0, 8'h00, 0);
        run_frame(1, 8'h01, 0, 9, 0, 8'h00, 0, 0, 8'h00, 0);
        // back to normal pace, empty frame
        ups = 1'b0;
        run_frame(0, 8'h00, 0, 7, 0, 8'h00, 0, 0, 8'h00, 0);

        chk(q.size() == 0, "R2", q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2: got 0 expected 1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule